// File: doc/BRIEF.md
# Quadratic Delay-Ratio Code Mapper

This block turns a measured cell-delay ratio into the starting control code of a ring oscillator whose delay-line length is selectable. The ratio compares the delay of one cell type with a reference cell type. Both delays shift with process, voltage and temperature, but they shift differently. A second-order curve in the ratio therefore predicts the current delay of one reference cell. The three coefficients of that curve are fitted per process corner and kept in a programmable store. They arrive here as plain inputs.

A start strobe captures the ratio and the three coefficients. The block evaluates the polynomial in Horner form on one shared multiplier. It then divides the target half-period of the 5 MHz output by the estimated cell delay, using a restoring divider, and clamps the quotient to the legal code range. A one-cycle valid pulse marks each new codeword. The codeword holds its value until the next result.

Top module: `qm_mapper`

## Requirements
- R1: After reset, `valid_o` is 0 and `code_o` equals CODE_MAX (the longest delay line).
- R2: The estimate is computed as D = ((((a·R) >>> 15) + b)·R >>> 15) + c. R is the unsigned Q1.15 ratio, and a, b and c are signed Q8.16 values. Each `>>>` is an arithmetic shift, which rounds toward minus infinity.
- R3: When D > 0 and the quotient lies in range, `code_o` = floor(HALF_PERIOD / D). HALF_PERIOD is the half-period in Q8.16 units, with a default of 6553600.
- R4: When D > 0 and the quotient exceeds CODE_MAX (default 2047), `code_o` = CODE_MAX.
- R5: When D > 0 and the quotient is below CODE_MIN (default 8), `code_o` = CODE_MIN.
- R6: When D ≤ 0, `code_o` = CODE_MAX.
- R7: `valid_o` is high for exactly one cycle. For D > 0 it rises HALF_W+4 cycles after the edge that samples `start_i`, where HALF_W = clog2(HALF_PERIOD+1) = 23. For D ≤ 0 it rises 3 cycles after that edge.
- R8: A `start_i` pulse that arrives while a computation is in progress is ignored. The result, its latency and the number of valid pulses are unchanged.
- R9: `code_o` changes only in a cycle where `valid_o` is high. Input changes without a start have no effect on it. A start that arrives in the same cycle as `valid_o` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Captures the inputs and starts a mapping when the block is idle |
| ratio_i | input | RATIO_W (16) | Delay ratio, unsigned Q1.15 |
| coef_a_i | input | COEF_W (24) | Quadratic coefficient, signed Q8.16 |
| coef_b_i | input | COEF_W (24) | Linear coefficient, signed Q8.16 |
| coef_c_i | input | COEF_W (24) | Constant coefficient, signed Q8.16 |
| code_o | output | CODE_W (11) | Oscillator delay-line codeword |
| valid_o | output | 1 | One-cycle pulse marking a new codeword |

## Verification
Two events can fall in one cycle: the valid pulse that ends a mapping, and the start strobe of the next one. The bench chains its operations so that each new start is driven in the very cycle it sees `valid_o` high. It then judges whether that start was taken, by the exact latency and the value of the following codeword. It also fires a second start in the middle of a running mapping, with different inputs, and checks that neither the result, nor the latency, nor the count of valid pulses moves.

// File: rtl/qm_pkg.sv
package qm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL1,
    ST_MUL2,
    ST_CHK,
    ST_DIV
  } qm_state_t;
endpackage

// File: rtl/qm_poly.sv
// Horner evaluator: one shared signed x unsigned multiplier, two steps.
module qm_poly #(
  parameter int RATIO_W = 16,
  parameter int COEF_W  = 24,
  parameter int ACC_W   = 28
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step_first,
  input  logic                     step_second,
  input  logic [RATIO_W-1:0]       ratio,
  input  logic signed [COEF_W-1:0] ca,
  input  logic signed [COEF_W-1:0] cb,
  input  logic signed [COEF_W-1:0] cc,
  output logic signed [ACC_W-1:0]  acc
);
  localparam int FRAC   = RATIO_W - 1;
  localparam int PROD_W = ACC_W + RATIO_W + 1;

  logic signed [ACC_W-1:0]  mul_x;
  logic signed [ACC_W-1:0]  add_y;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] full;
  logic signed [ACC_W-1:0]  acc_q;

  always_comb begin
    if (step_second) begin
      mul_x = acc_q;
      add_y = ACC_W'(cc);
    end else begin
      mul_x = ACC_W'(ca);
      add_y = ACC_W'(cb);
    end
    prod = PROD_W'(mul_x) * $signed({1'b0, ratio});
    full = (prod >>> FRAC) + PROD_W'(add_y);
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (step_first || step_second) acc_q <= full[ACC_W-1:0];
  end

  assign acc = acc_q;

  // R2: the accumulator is wide enough, so nothing is lost by truncation
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    (step_first || step_second) |->
      ((full[PROD_W-1:ACC_W-1] == '0) || (full[PROD_W-1:ACC_W-1] == '1)));

  // R2: the two steps never coincide
  p_step_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(step_first && step_second));
endmodule

// File: rtl/qm_div.sv
// Restoring divider: one quotient bit per cycle, NUM_W cycles.
module qm_div #(
  parameter int NUM_W = 23,
  parameter int DEN_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [NUM_W-1:0] nsh_q;
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W:0]   trial;
  logic [DEN_W+1:0] diff;
  logic             take;

  always_comb begin
    trial = {rem_q, nsh_q[NUM_W-1]};
    diff  = {1'b0, trial} - {2'b00, den_q};
    take  = !diff[DEN_W+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      nsh_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
      den_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(NUM_W);
      nsh_q <= num;
      quo_q <= '0;
      rem_q <= '0;
      den_q <= den;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      nsh_q <= {nsh_q[NUM_W-2:0], 1'b0};
      quo_q <= {quo_q[NUM_W-2:0], take};
      rem_q <= take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
    end
  end

  assign busy = (cnt_q != '0);
  assign quo  = quo_q;

  // R3: the partial remainder stays below the divisor
  p_rem_below_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rem_q < den_q));

  // R3: a subtraction result always fits back into the remainder
  p_rem_fit_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && take) |-> !diff[DEN_W]);

  // R3: a zero divisor is never loaded
  p_den_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    load |-> (den != '0));
endmodule

// File: rtl/qm_mapper.sv
module qm_mapper
  import qm_pkg::*;
#(
  parameter int RATIO_W     = 16,
  parameter int COEF_W      = 24,
  parameter int CODE_W      = 11,
  parameter int CODE_MIN    = 8,
  parameter int CODE_MAX    = 2047,
  parameter int HALF_PERIOD = 6553600
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [RATIO_W-1:0]       ratio_i,
  input  logic signed [COEF_W-1:0] coef_a_i,
  input  logic signed [COEF_W-1:0] coef_b_i,
  input  logic signed [COEF_W-1:0] coef_c_i,
  output logic [CODE_W-1:0]        code_o,
  output logic                     valid_o
);
  localparam int HALF_W = $clog2(HALF_PERIOD + 1);
  localparam int ACC_W  = COEF_W + 4;
  localparam logic [HALF_W-1:0] LIM_HI = HALF_W'(CODE_MAX);
  localparam logic [HALF_W-1:0] LIM_LO = HALF_W'(CODE_MIN);

  qm_state_t                state_q;
  logic [RATIO_W-1:0]       rat_q;
  logic signed [COEF_W-1:0] ca_q, cb_q, cc_q;
  logic signed [ACC_W-1:0]  est;
  logic                     div_busy;
  logic [HALF_W-1:0]        div_quo;
  logic                     est_pos;
  logic                     accept;
  logic [CODE_W-1:0]        code_q;
  logic                     valid_q;

  assign accept  = start_i && (state_q == ST_IDLE);
  assign est_pos = !est[ACC_W-1] && (est != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rat_q <= '0;
      ca_q  <= '0;
      cb_q  <= '0;
      cc_q  <= '0;
    end else if (accept) begin
      rat_q <= ratio_i;
      ca_q  <= coef_a_i;
      cb_q  <= coef_b_i;
      cc_q  <= coef_c_i;
    end
  end

  qm_poly #(
    .RATIO_W(RATIO_W),
    .COEF_W (COEF_W),
    .ACC_W  (ACC_W)
  ) u_poly (
    .clk        (clk),
    .rst        (rst),
    .step_first (state_q == ST_MUL1),
    .step_second(state_q == ST_MUL2),
    .ratio      (rat_q),
    .ca         (ca_q),
    .cb         (cb_q),
    .cc         (cc_q),
    .acc        (est)
  );

  qm_div #(
    .NUM_W(HALF_W),
    .DEN_W(ACC_W)
  ) u_div (
    .clk (clk),
    .rst (rst),
    .load((state_q == ST_CHK) && est_pos),
    .num (HALF_W'(HALF_PERIOD)),
    .den (est),
    .busy(div_busy),
    .quo (div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      code_q  <= CODE_W'(CODE_MAX);
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_MUL1;
        ST_MUL1: state_q <= ST_MUL2;
        ST_MUL2: state_q <= ST_CHK;
        ST_CHK: begin
          if (est_pos) begin
            state_q <= ST_DIV;
          end else begin
            code_q  <= CODE_W'(CODE_MAX);
            valid_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_DIV: begin
          if (!div_busy) begin
            if (div_quo > LIM_HI)      code_q <= CODE_W'(CODE_MAX);
            else if (div_quo < LIM_LO) code_q <= CODE_W'(CODE_MIN);
            else                       code_q <= div_quo[CODE_W-1:0];
            valid_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign code_o  = code_q;
  assign valid_o = valid_q;

  // R7: valid lasts one cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R9: the codeword only moves together with valid
  p_code_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(code_o) |-> valid_o);

  // R4 R5: every published code lies in the legal range
  p_code_range_r4: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((code_o >= CODE_W'(CODE_MIN)) && (code_o <= CODE_W'(CODE_MAX))));

  // R6: a non-positive estimate publishes the maximum code next cycle
  p_nonpos_max_r6: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_CHK) && !est_pos) |=> (valid_o && (code_o == CODE_W'(CODE_MAX))));

  // R8: a start during a computation does not disturb the captured operands
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (start_i && (state_q != ST_IDLE)) |=> $stable(rat_q));
endmodule

// File: tb/test_qm_mapper.sv
module test_qm_mapper;
  localparam int CLK_NS   = 10;
  localparam int RW       = 16;
  localparam int CW       = 24;
  localparam int KW       = 11;
  localparam int KMIN     = 8;
  localparam int KMAX     = 2047;
  localparam longint HALF = 6553600;
  localparam int HW       = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [RW-1:0] ratio_i = '0;
  logic signed [CW-1:0] coef_a_i = '0, coef_b_i = '0, coef_c_i = '0;
  logic [KW-1:0] code_o;
  logic valid_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  qm_mapper i_qm_mapper (
    .clk(clk), .rst(rst), .start_i(start_i), .ratio_i(ratio_i),
    .coef_a_i(coef_a_i), .coef_b_i(coef_b_i), .coef_c_i(coef_c_i),
    .code_o(code_o), .valid_o(valid_o)
  );

  function automatic longint est_of(longint a, longint b, longint c, longint r);
    longint p1;
    p1 = ((a * r) >>> 15) + b;
    return ((p1 * r) >>> 15) + c;
  endfunction

  function automatic longint code_of(longint d);
    longint q;
    if (d <= 0) return KMAX;
    q = HALF / d;
    if (q > KMAX) return KMAX;
    if (q < KMIN) return KMIN;
    return q;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive start at a falling edge, wait for valid, check code and latency.
  task automatic run_op(input longint a, input longint b, input longint c, input longint r,
                        input bit poke_busy);
    longint d, exp;
    int lat;
    string tag;
    d   = est_of(a, b, c, r);
    exp = code_of(d);
    ratio_i  = RW'(r);
    coef_a_i = CW'(a);
    coef_b_i = CW'(b);
    coef_c_i = CW'(c);
    start_i  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!valid_o && lat < 100) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (poke_busy && lat == 5) begin
        ratio_i  = RW'(r ^ 16'h5a5a);
        coef_c_i = CW'(c + 777);
        start_i  = 1'b1;
      end else begin
        start_i = 1'b0;
      end
    end
    if (d <= 0) tag = "R6";
    else if (HALF / d > KMAX) tag = "R4";
    else if (HALF / d < KMIN) tag = "R5";
    else tag = "R2 R3";
    check(code_o == KW'(exp), tag, code_o, exp);
    check(lat == ((d > 0) ? HW + 4 : 3), "R7 latency", lat, (d > 0) ? HW + 4 : 3);
    if (poke_busy) check(code_o == KW'(exp), "R8 result", code_o, exp);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint coefs [8][3];
    coefs[0] = '{0, 0, 5000};
    coefs[1] = '{1500, -800, 3200};
    coefs[2] = '{-1200, 2600, 4100};
    coefs[3] = '{40000, -30000, 9000};
    coefs[4] = '{0, 0, 100};
    coefs[5] = '{0, 0, 1638400};
    coefs[6] = '{-9000, -4000, 2000};
    coefs[7] = '{300000, 500000, 700000};

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(valid_o == 1'b0, "R1 valid", valid_o, 0);
    check(code_o == KW'(KMAX), "R1 code", code_o, KMAX);

    // Back-to-back sweep: each start lands in the valid cycle of the previous op (R9)
    for (int k = 0; k < 8; k++) begin
      for (int r = 0; r < 65536; r += 2047)
        run_op(coefs[k][0], coefs[k][1], coefs[k][2], r, 1'b0);
      run_op(coefs[k][0], coefs[k][1], coefs[k][2], 65535, 1'b0);
    end
    run_op(0, 0, 0, 30000, 1'b0);
    run_op(0, 0, -5, 0, 1'b0);

    // R7: valid falls after one cycle
    @(posedge clk);
    @(negedge clk);
    check(valid_o == 1'b0, "R7 pulse width", valid_o, 0);

    // R8: start while busy is ignored, and no extra valid follows
    run_op(1500, -800, 3200, 40000, 1'b1);
    begin
      int extra = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (valid_o) extra++;
      end
      check(extra == 0, "R8 extra valid", extra, 0);
    end

    // R9: inputs change with no start, code must hold
    begin
      logic [KW-1:0] held;
      held = code_o;
      ratio_i  = 16'h1234;
      coef_c_i = 24'sd100;
      repeat (20) @(negedge clk);
      check(code_o == held && !valid_o, "R9 hold", code_o, held);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule